// File: doc/BRIEF.md
# Receive Frame Address Filter

This block sits in an infrared receive path, after the stage that finds flags and removes stuffing, and before the receive buffer. It watches a byte stream marked with frame-open, byte-valid, frame-close and abort indications. It decides, once per frame, whether the bytes of that frame may be written to the buffer. The first data byte after an opening flag is the station address. When filtering is on, that address is compared with a programmable match value. A frame whose address matches, or whose address is all ones, is forwarded whole: the address byte, the control byte and the data bytes. Any other frame is discarded up to the next flag. When filtering is off, every frame is forwarded.

Software may rewrite the match value and the enable at any time, including while a frame is arriving. The block copies both settings at the opening flag and uses that copy for the whole frame, so a new setting takes effect from the next frame. At the close of each frame, the block gives a single-cycle pulse that marks the frame as accepted or rejected. The match value has no defined power-up meaning, so software loads it before switching the receiver on.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, the buffer write strobe, the accept pulse and the reject pulse are all low.
- R2: The block writes nothing to the buffer for bytes, closes or aborts that arrive outside a frame: after reset before any flag, and after a frame close before the next flag.
- R3: With the frame's captured enable at 0, every byte of the frame is written, in order, and the close gives an accept pulse.
- R4: With the enable at 1 and an address byte equal to the captured match value, the address byte and every later byte of the frame are written in order. Each byte appears on the write port one clock cycle after it is presented.
- R5: With the enable at 1 and an address byte that is neither equal to the match value nor all ones, no byte of the frame is written, and the close gives a reject pulse.
- R6: With the enable at 1, an address byte of all ones (FFh for 8-bit data) is accepted, whatever the match value.
- R7: The match value and the enable are captured at the opening flag. A change during a frame does not alter that frame's decision, and it applies to the next frame.
- R8: A frame that closes before any address byte arrives writes nothing and gives a reject pulse.
- R9: An abort inside a frame returns the block to waiting for an address byte, using the same captured settings. The next byte is judged again as an address. The abort gives no status pulse.
- R10: A flag inside a frame starts a new frame with freshly captured settings. The interrupted frame gives no status pulse.
- R11: Accept and reject are single-cycle pulses, never high together, and exactly one of them follows each frame close inside a frame. The pulse arrives one cycle after the close.
- R12: When several indications arrive in one cycle, flag wins over abort, abort wins over close, and close wins over byte-valid. The lower-priority indications in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_match | input | DATA_W | Programmable address match value |
| cfg_enable | input | 1 | Address filtering enable |
| in_sof | input | 1 | Opening flag seen; starts a frame |
| in_abort | input | 1 | Abort inside a frame |
| in_eof | input | 1 | Frame close |
| in_valid | input | 1 | A received byte is present on in_data |
| in_data | input | DATA_W | Received byte |
| buf_wr | output | 1 | Write strobe for the receive buffer |
| buf_data | output | DATA_W | Byte to write to the buffer |
| frm_accept | output | 1 | Pulse: the frame that just closed was kept |
| frm_reject | output | 1 | Pulse: the frame that just closed was dropped |

## Verification
The bench builds the block with DATA_W at 8 and two reset synchronizer stages. With these values, the broadcast address is the literal FFh, and it can be set against match values next to it (FEh, 7Fh) to check that only an exact all-ones byte passes. The short synchronizer means the block is ready a few cycles after reset. This leaves room for the same-cycle priority cases, for flags and aborts in the middle of a frame, and for changes to the settings placed between the flag and the address byte.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

  // Filter position within the received stream
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // outside any frame
    ST_ADDR = 2'd1,  // frame open, waiting for the address byte
    ST_PASS = 2'd2,  // frame accepted, forwarding bytes
    ST_DROP = 2'd3   // frame rejected, discarding until next flag
  } rxaf_state_e;

endpackage

// File: rtl/rxaf_rst_sync.sv
module rxaf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/rxaf_cfg_snap.sv
module rxaf_cfg_snap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap_en,
  input  logic [DATA_W-1:0] match_i,
  input  logic              enable_i,
  output logic [DATA_W-1:0] match_q,
  output logic              enable_q
);

  logic [DATA_W-1:0] match_d;
  logic              enable_d;

  always_comb begin
    match_d  = match_q;
    enable_d = enable_q;
    if (snap_en) begin
      match_d  = match_i;
      enable_d = enable_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q  <= '0;
      enable_q <= 1'b0;
    end else begin
      match_q  <= match_d;
      enable_q <= enable_d;
    end
  end

endmodule

// File: rtl/rxaf_fsm.sv
module rxaf_fsm
  import rxaf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_sof,
  input  logic              in_abort,
  input  logic              in_eof,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] snap_match,
  input  logic              snap_enable,
  output rxaf_state_e       state_o,
  output logic              ev_byte_o,
  output logic              wr_o,
  output logic              acc_o,
  output logic              rej_o
);

  localparam logic [DATA_W-1:0] BCAST = {DATA_W{1'b1}};

  rxaf_state_e state_q, state_d;
  logic ev_abort, ev_eof, ev_byte, addr_hit;

  // Priority: flag, then abort, then close, then byte
  always_comb begin
    ev_abort = !in_sof && in_abort;
    ev_eof   = !in_sof && !in_abort && in_eof;
    ev_byte  = !in_sof && !in_abort && !in_eof && in_valid;
    addr_hit = !snap_enable || (in_data == snap_match) || (in_data == BCAST);
  end

  always_comb begin
    state_d = state_q;
    wr_o    = 1'b0;
    acc_o   = 1'b0;
    rej_o   = 1'b0;
    if (in_sof) begin
      state_d = ST_ADDR;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (ev_abort) state_d = ST_ADDR;
          else if (ev_eof) begin
            state_d = ST_IDLE;
            rej_o   = 1'b1;
          end else if (ev_byte) begin
            state_d = addr_hit ? ST_PASS : ST_DROP;
            wr_o    = addr_hit;
          end
        end
        ST_PASS: begin
          if (ev_abort) state_d = ST_ADDR;
          else if (ev_eof) begin
            state_d = ST_IDLE;
            acc_o   = 1'b1;
          end else if (ev_byte) wr_o = 1'b1;
        end
        ST_DROP: begin
          if (ev_abort) state_d = ST_ADDR;
          else if (ev_eof) begin
            state_d = ST_IDLE;
            rej_o   = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o   = state_q;
  assign ev_byte_o = ev_byte;

endmodule

// File: rtl/rxaf_out_reg.sv
module rxaf_out_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              acc_i,
  input  logic              rej_i,
  output logic              wr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              acc_q,
  output logic              rej_q
);

  logic [DATA_W-1:0] data_d;

  // Data register only loads on a write
  always_comb begin
    data_d = wr_i ? data_i : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      data_q <= '0;
      acc_q  <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      wr_q   <= wr_i;
      data_q <= data_d;
      acc_q  <= acc_i;
      rej_q  <= rej_i;
    end
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cfg_match,
  input  logic              cfg_enable,
  input  logic              in_sof,
  input  logic              in_abort,
  input  logic              in_eof,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              buf_wr,
  output logic [DATA_W-1:0] buf_data,
  output logic              frm_accept,
  output logic              frm_reject
);

  localparam logic [DATA_W-1:0] BCAST = {DATA_W{1'b1}};

  logic              srst_n;
  logic [DATA_W-1:0] snap_match;
  logic              snap_enable;
  rxaf_state_e       state;
  logic              ev_byte, wr_c, acc_c, rej_c;

  rxaf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  rxaf_cfg_snap #(.DATA_W(DATA_W)) u_snap (
    .clk(clk), .rst_n(srst_n), .snap_en(in_sof),
    .match_i(cfg_match), .enable_i(cfg_enable),
    .match_q(snap_match), .enable_q(snap_enable)
  );

  rxaf_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(srst_n),
    .in_sof(in_sof), .in_abort(in_abort), .in_eof(in_eof),
    .in_valid(in_valid), .in_data(in_data),
    .snap_match(snap_match), .snap_enable(snap_enable),
    .state_o(state), .ev_byte_o(ev_byte),
    .wr_o(wr_c), .acc_o(acc_c), .rej_o(rej_c)
  );

  rxaf_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(srst_n),
    .wr_i(wr_c), .data_i(in_data), .acc_i(acc_c), .rej_i(rej_c),
    .wr_q(buf_wr), .data_q(buf_data), .acc_q(frm_accept), .rej_q(frm_reject)
  );

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!srst_n)
    !(frm_accept && frm_reject)) else $error("accept and reject together"); // R11

  AST_STATUS_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!srst_n)
    (frm_accept || frm_reject) |-> $past(in_eof && !in_sof && !in_abort)) else $error("status without close"); // R11

  AST_WR_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!srst_n)
    buf_wr |-> $past(in_valid && !in_sof && !in_abort && !in_eof)) else $error("write without byte"); // R12

  AST_WR_DATA_ECHO: assert property (@(posedge clk) disable iff (!srst_n)
    buf_wr |-> (buf_data == $past(in_data))) else $error("write data mismatch"); // R4

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_DROP && ev_byte) |=> !buf_wr) else $error("dropped frame wrote"); // R5

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_IDLE && !in_sof) |=> (!buf_wr && !frm_accept && !frm_reject)) else $error("activity outside frame"); // R2

  AST_BCAST_PASS: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_ADDR && ev_byte && in_data == BCAST) |=> buf_wr) else $error("broadcast not written"); // R6

  AST_EMPTY_REJECT: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_ADDR && !in_sof && !in_abort && in_eof) |=> (frm_reject && !buf_wr)) else $error("empty frame not rejected"); // R8

endmodule

// File: tb/rx_addr_filter_bench.sv
`timescale 1ns/1ps
module rx_addr_filter_bench;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] cfg_match;
  logic          cfg_enable;
  logic          in_sof, in_abort, in_eof, in_valid;
  logic [DW-1:0] in_data;
  logic          buf_wr, frm_accept, frm_reject;
  logic [DW-1:0] buf_data;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R2";

  // Scoreboard queues
  logic [DW-1:0] exp_wr_q[$];
  string         exp_wr_tag[$];
  logic          exp_st_q[$];   // 1 accept, 0 reject
  string         exp_st_tag[$];

  // Bench model of the frame decision
  int            m_state = 0;   // 0 idle, 1 addr, 2 pass, 3 drop
  logic [DW-1:0] m_match;
  logic          m_en;

  always #2.5 clk = ~clk;

  rx_addr_filter #(.DATA_W(DW), .SYNC_STAGES(2)) u_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .cfg_match(cfg_match), .cfg_enable(cfg_enable),
    .in_sof(in_sof), .in_abort(in_abort), .in_eof(in_eof),
    .in_valid(in_valid), .in_data(in_data),
    .buf_wr(buf_wr), .buf_data(buf_data),
    .frm_accept(frm_accept), .frm_reject(frm_reject)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clr;
    in_sof = 0; in_abort = 0; in_eof = 0; in_valid = 0; in_data = '0;
  endtask

  task automatic cyc;
    @(negedge clk);
    clr();
  endtask

  task automatic flag;
    in_sof = 1;
    m_state = 1; m_match = cfg_match; m_en = cfg_enable;
    cyc();
  endtask

  task automatic abort_in;
    in_abort = 1;
    if (m_state != 0) m_state = 1;
    cyc();
  endtask

  task automatic close(input string tag);
    in_eof = 1;
    if (m_state != 0) begin
      exp_st_q.push_back(m_state == 2);
      exp_st_tag.push_back(tag);
      m_state = 0;
    end
    cyc();
  endtask

  task automatic put(input logic [DW-1:0] b, input string tag);
    in_valid = 1; in_data = b;
    if (m_state == 1) begin
      if (!m_en || b == m_match || b == '1) m_state = 2;
      else m_state = 3;
    end
    if (m_state == 2) begin
      exp_wr_q.push_back(b);
      exp_wr_tag.push_back(tag);
    end
    cyc();
  endtask

  task automatic frame(input logic [DW-1:0] addr, input int n, input string tag);
    flag();
    put(addr, tag);
    for (int i = 0; i < n; i++) put(8'(addr + 8'(i) * 8'd7 + 8'd1), tag);
    close(tag);
  endtask

  task automatic drain;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: compares outputs as they appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        if (buf_wr) begin
          if (exp_wr_q.size() == 0)
            check(0, cur_tag, "unexpected write", int'(buf_data), 0);
          else begin
            automatic logic [DW-1:0] e = exp_wr_q.pop_front();
            automatic string t = exp_wr_tag.pop_front();
            check(buf_data == e, t, "write data", int'(buf_data), int'(e));
          end
        end
        if (frm_accept && frm_reject)
          check(0, "R11", "both status pulses", 1, 0);
        else if (frm_accept || frm_reject) begin
          if (exp_st_q.size() == 0)
            check(0, cur_tag, "unexpected status", int'(frm_accept), 0);
          else begin
            automatic logic e = exp_st_q.pop_front();
            automatic string t = exp_st_tag.pop_front();
            check(frm_accept == e, t, "status accept", int'(frm_accept), int'(e));
          end
        end
      end
    end
  end

  task automatic expect_empty(input string tag);
    check(exp_wr_q.size() == 0, tag, "missing writes", exp_wr_q.size(), 0);
    check(exp_st_q.size() == 0, tag, "missing status", exp_st_q.size(), 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clr();
    cfg_match = 8'h00; cfg_enable = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(buf_wr == 0 && frm_accept == 0 && frm_reject == 0, "R1", "reset outputs",
          int'({buf_wr, frm_accept, frm_reject}), 0);

    // R2: stray bytes, closes and aborts before any flag
    cur_tag = "R2";
    put(8'h11, "R2"); put(8'h22, "R2"); close("R2"); abort_in(); drain();
    expect_empty("R2");

    // R3: filtering off, any address passes
    cur_tag = "R3";
    cfg_match = 8'h42; cfg_enable = 0;
    frame(8'h99, 3, "R3"); drain(); expect_empty("R3");

    // R4: filtering on, exact match, with gaps between bytes
    cur_tag = "R4";
    cfg_enable = 1; cfg_match = 8'h42;
    flag(); put(8'h42, "R4"); cyc(); put(8'h03, "R4"); cyc(); cyc(); put(8'hA5, "R4");
    close("R4"); drain(); expect_empty("R4");

    // R5: mismatch dropped
    cur_tag = "R5";
    frame(8'h43, 4, "R5"); drain(); expect_empty("R5");

    // R2: bytes after a close, before the next flag
    cur_tag = "R2";
    put(8'h42, "R2"); put(8'h55, "R2"); drain(); expect_empty("R2");

    // R6: broadcast, and near-broadcast values
    cur_tag = "R6";
    cfg_match = 8'hFE;
    frame(8'hFF, 2, "R6");
    frame(8'h7F, 2, "R6");
    cfg_match = 8'h00;
    frame(8'hFF, 1, "R6"); drain(); expect_empty("R6");

    // R7: settings change within a frame
    cur_tag = "R7";
    cfg_match = 8'h12; cfg_enable = 1;
    flag(); cfg_match = 8'h34;
    put(8'h12, "R7"); put(8'h01, "R7"); close("R7");
    frame(8'h12, 1, "R7");
    frame(8'h34, 1, "R7");
    cfg_match = 8'h55; cfg_enable = 1;
    flag(); cfg_enable = 0;
    put(8'h77, "R7"); put(8'h02, "R7"); close("R7");
    frame(8'h77, 1, "R7");
    drain(); expect_empty("R7");

    // R8: frame closes before address
    cur_tag = "R8";
    cfg_enable = 0;
    flag(); close("R8");
    cfg_enable = 1; flag(); cyc(); close("R8");
    drain(); expect_empty("R8");

    // R9: abort mid-frame, next byte is address again
    cur_tag = "R9";
    cfg_enable = 1; cfg_match = 8'h20;
    flag(); put(8'h20, "R9"); put(8'h01, "R9"); abort_in();
    put(8'h21, "R9"); put(8'h02, "R9"); close("R9");
    flag(); put(8'h30, "R9"); abort_in(); put(8'h20, "R9"); put(8'h03, "R9"); close("R9");
    drain(); expect_empty("R9");

    // R10: new flag mid-frame with new settings
    cur_tag = "R10";
    cfg_match = 8'h40;
    flag(); put(8'h40, "R10"); put(8'h05, "R10");
    cfg_match = 8'h41;
    flag(); put(8'h40, "R10"); put(8'h06, "R10"); close("R10");
    flag(); put(8'h41, "R10"); close("R10");
    drain(); expect_empty("R10");

    // R12: simultaneous indications
    cur_tag = "R12";
    cfg_match = 8'h60;
    // close with a byte: byte ignored, frame empty -> reject
    flag(); in_eof = 1; in_valid = 1; in_data = 8'h60;
    exp_st_q.push_back(0); exp_st_tag.push_back("R12"); m_state = 0; cyc();
    // abort with close and byte: stays in frame, only abort acts
    flag(); put(8'h60, "R12");
    in_abort = 1; in_eof = 1; in_valid = 1; in_data = 8'h61; m_state = 1; cyc();
    put(8'h61, "R12"); close("R12");
    // flag with close and byte: starts a frame, nothing else
    in_sof = 1; in_eof = 1; in_abort = 1; in_valid = 1; in_data = 8'h60;
    m_state = 1; m_match = cfg_match; m_en = cfg_enable; cyc();
    put(8'h60, "R12"); close("R12");
    drain(); expect_empty("R12");

    // R11: back-to-back frames give one pulse each
    cur_tag = "R11";
    cfg_match = 8'h70;
    flag(); put(8'h70, "R11"); close("R11");
    flag(); put(8'h71, "R11"); close("R11");
    flag(); close("R11");
    drain(); expect_empty("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule